// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register Window

This block is the memory-mapped front end of a multi-pin interrupt redirection controller. Software reaches all of the controller's state through two words only: an 8-bit select register and a 32-bit data window. The select value picks what the window reaches. It can pick the controller identifier, a read-only version word, or one 32-bit half of a 64-bit redirection entry. Each interrupt pin has one redirection entry.

The whole redirection table leaves the block in parallel, so the delivery logic can use it. The delivery logic reports back through a per-pin input that sets the remote-IRR status bit of an entry. The block sends a one-cycle strobe with the entry index after each table write. It sends a second strobe when a write changes an entry's mask bit. Read data is combinational from the current address, length and state. Writes take effect at the clock edge.

Top module: `irq_regwin`

## Requirements
- R1: Only address bits [7:0] are decoded. Offset 0x00 is the select register and offset 0x10 is the data window. Any other offset reads 0x00000000 and ignores writes.
- R2: A write to the select register keeps the low 8 bits of the effective write data. A read of offset 0x00 returns the select value zero-extended to 32 bits.
- R3: The access length is a byte count. Lengths 1 and 2 zero-extend the write data from its low 8 or 16 bits and mask the read data to 8 or 16 bits. Lengths 4 and 8 use all 32 bits. Any other length drops the write and reads 0.
- R4: Select 0x00 (identifier) and select 0x02 (arbitration) both read the 4-bit identifier in bits [27:24], with all other bits zero. A window write with select 0x00 stores data bits [27:24]. A window write with select 0x02 is ignored.
- R5: Select 0x01 reads NUM_PINS-1 in bits [23:16] and the VERSION code (default 0x11) in bits [7:0], with all other bits zero. Writes to it change nothing.
- R6: A select value s >= 0x10 reaches entry (s-0x10)>>1. An odd s reaches entry bits [63:32] and an even s reaches bits [31:0]. A write replaces only that half.
- R7: An entry index >= NUM_PINS, and any select from 0x03 to 0x0F, reads 0xFFFFFFFF. A write there changes no entry and gives no strobe.
- R8: Reset clears the select register and the identifier. It sets every entry to 0x0000000000010000, which has only the mask bit (bit 16) set.
- R9: Bit 14 of an entry is remote IRR. A pulse on rirr_set_i[n] sets it in entry n. A low-half write clears it whatever data bit 14 holds. A high-half write keeps it. If a set and a low-half write reach the same entry in the same cycle, the set wins.
- R10: In the cycle after each entry write, entry_wr_o is high for one cycle and entry_idx_o holds the entry index. mask_chg_o pulses in that same cycle only when the write changed the entry's mask bit 16.
- R11: table_o carries entry n in bits [64n+63:64n]. The field layout is vector [7:0], delivery mode [10:8], destination mode [11], remote IRR [14], trigger mode [15] (1 = level), mask [16] and destination ID [63:56].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Access request |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address, only bits [7:0] decoded |
| bus_len_i | input | 4 | Access length in bytes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address |
| rirr_set_i | input | NUM_PINS | Per-entry remote-IRR set pulse from delivery logic |
| table_o | output | NUM_PINS*64 | Whole redirection table |
| entry_wr_o | output | 1 | One-cycle pulse after an entry write |
| entry_idx_o | output | IDX_W | Index of the entry last written |
| mask_chg_o | output | 1 | One-cycle pulse when a write changed a mask bit |

## Verification
A wrong select decode, for example a mix-up between the halves or an index off by one, shows in the same cycle. The window then reads the wrong half or the wrong entry, and the written bits appear in another slice of table_o one cycle after the write. A remote-IRR bit that stays set, or one whose value comes from data bit 14, shows on the next window read of the low half after the write. A wrong mask-change comparison shows as a missing or extra mask_chg_o pulse in the cycle after the write, because entry_wr_o and entry_idx_o make that cycle easy to recognise.

// File: rtl/irw_pkg.sv
package irw_pkg;
  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;
  localparam logic [7:0] SEL_TBL = 8'h10;
  localparam int RIRR_BIT = 14;
  localparam int MASK_BIT = 16;
  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {K_ID, K_VER, K_ARB, K_TBL, K_VOID} win_kind_e;
endpackage

// File: rtl/irw_decode.sv
module irw_decode import irw_pkg::*; #(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = 5
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        len_i,
  input  logic [31:0]       wdata_i,
  input  logic [7:0]        sel_i,
  output logic              off_sel_o,
  output logic              off_win_o,
  output logic              len_ok_o,
  output logic [31:0]       lane_o,
  output logic [31:0]       wdata_o,
  output win_kind_e         kind_o,
  output logic              hi_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              sel_we_o,
  output logic              id_we_o,
  output logic              tbl_we_o
);
  logic [7:0] off;
  logic [7:0] tbl_raw;
  logic       wr;
  logic       unused_bits;

  assign off       = addr_i[7:0];
  assign off_sel_o = (off == OFF_SEL);
  assign off_win_o = (off == OFF_WIN);

  always_comb begin
    len_ok_o = 1'b1;
    unique case (len_i)
      4'd1:       lane_o = 32'h0000_00ff;
      4'd2:       lane_o = 32'h0000_ffff;
      4'd4, 4'd8: lane_o = 32'hffff_ffff;
      default: begin lane_o = '0; len_ok_o = 1'b0; end
    endcase
  end
  assign wdata_o = wdata_i & lane_o;

  assign tbl_raw = (sel_i - SEL_TBL) >> 1;
  assign idx_o   = tbl_raw[IDX_W-1:0];
  assign hi_o    = sel_i[0];

  always_comb begin
    if (sel_i == SEL_ID)       kind_o = K_ID;
    else if (sel_i == SEL_VER) kind_o = K_VER;
    else if (sel_i == SEL_ARB) kind_o = K_ARB;
    else if (sel_i >= SEL_TBL && {24'b0, tbl_raw} < 32'(NUM_PINS)) kind_o = K_TBL;
    else                       kind_o = K_VOID;
  end

  assign wr       = valid_i & write_i & len_ok_o;
  assign sel_we_o = wr & off_sel_o;
  assign id_we_o  = wr & off_win_o & (kind_o == K_ID);
  assign tbl_we_o = wr & off_win_o & (kind_o == K_TBL);

  assign unused_bits = ^{tbl_raw, addr_i};
endmodule

// File: rtl/irw_entry.sv
module irw_entry import irw_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_lo_i,
  input  logic        we_hi_i,
  input  logic [31:0] wdata_i,
  input  logic        rirr_set_i,
  output logic [63:0] entry_o,
  output logic        mask_flip_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) entry_o <= ENTRY_RST;
    else begin
      if (we_hi_i) entry_o[63:32] <= wdata_i;
      if (we_lo_i) begin
        entry_o[31:0]    <= wdata_i;
        entry_o[RIRR_BIT] <= 1'b0;  // status bit is hardware-owned
      end
      if (rirr_set_i) entry_o[RIRR_BIT] <= 1'b1;
    end
  end

  assign mask_flip_o = we_lo_i & (wdata_i[MASK_BIT] != entry_o[MASK_BIT]);

  assert_rirr_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_lo_i && !rirr_set_i |=> !entry_o[RIRR_BIT]);
  assert_rirr_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rirr_set_i |=> entry_o[RIRR_BIT]);
  assert_hi_keeps_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_hi_i && !we_lo_i && !rirr_set_i |=> $stable(entry_o[31:0]));
  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_lo_i && !we_hi_i && !rirr_set_i |=> $stable(entry_o));
endmodule

// File: rtl/irw_rdmux.sv
module irw_rdmux import irw_pkg::*; #(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h11
) (
  input  logic        off_sel_i,
  input  logic        off_win_i,
  input  logic        len_ok_i,
  input  logic [31:0] lane_i,
  input  win_kind_e   kind_i,
  input  logic        hi_i,
  input  logic [7:0]  sel_i,
  input  logic [3:0]  id_i,
  input  logic [63:0] entry_i,
  output logic [31:0] rdata_o
);
  logic [31:0] raw;

  always_comb begin
    raw = '0;
    if (off_sel_i) raw = {24'b0, sel_i};
    else if (off_win_i) begin
      unique case (kind_i)
        K_ID, K_ARB: raw = {4'b0, id_i, 24'b0};
        K_VER:       raw = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};
        K_TBL:       raw = hi_i ? entry_i[63:32] : entry_i[31:0];
        default:     raw = '1;
      endcase
    end
  end

  assign rdata_o = len_ok_i ? (raw & lane_i) : '0;
endmodule

// File: rtl/irq_regwin.sv
module irq_regwin import irw_pkg::*; #(
  parameter int         NUM_PINS = 24,
  parameter int         ADDR_W   = 12,
  parameter logic [7:0] VERSION  = 8'h11,
  localparam int        IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bus_valid_i,
  input  logic                    bus_write_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [3:0]              bus_len_i,
  input  logic [31:0]             bus_wdata_i,
  output logic [31:0]             bus_rdata_o,
  input  logic [NUM_PINS-1:0]     rirr_set_i,
  output logic [NUM_PINS*64-1:0]  table_o,
  output logic                    entry_wr_o,
  output logic [IDX_W-1:0]        entry_idx_o,
  output logic                    mask_chg_o
);
  logic [7:0]  sel_q;
  logic [3:0]  id_q;
  logic        off_sel, off_win, len_ok, hi;
  logic [31:0] lane, wdata_eff;
  win_kind_e   kind;
  logic [IDX_W-1:0] tbl_idx;
  logic        sel_we, id_we, tbl_we;
  logic [NUM_PINS-1:0] we_lo, we_hi, mask_flip;
  logic [63:0] ent [NUM_PINS];
  logic [63:0] entry_rd;

  irw_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .valid_i(bus_valid_i), .write_i(bus_write_i), .addr_i(bus_addr_i),
    .len_i(bus_len_i), .wdata_i(bus_wdata_i), .sel_i(sel_q),
    .off_sel_o(off_sel), .off_win_o(off_win), .len_ok_o(len_ok),
    .lane_o(lane), .wdata_o(wdata_eff), .kind_o(kind), .hi_o(hi),
    .idx_o(tbl_idx), .sel_we_o(sel_we), .id_we_o(id_we), .tbl_we_o(tbl_we));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_we) sel_q <= wdata_eff[7:0];
      if (id_we)  id_q  <= wdata_eff[27:24];
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    assign we_lo[g] = tbl_we & ~hi & (tbl_idx == IDX_W'(g));
    assign we_hi[g] = tbl_we &  hi & (tbl_idx == IDX_W'(g));
    irw_entry u_ent (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_lo_i(we_lo[g]), .we_hi_i(we_hi[g]),
      .wdata_i(wdata_eff), .rirr_set_i(rirr_set_i[g]),
      .entry_o(ent[g]), .mask_flip_o(mask_flip[g]));
    assign table_o[g*64 +: 64] = ent[g];
  end

  always_comb begin
    entry_rd = '1;
    for (int i = 0; i < NUM_PINS; i++)
      if (tbl_idx == IDX_W'(i)) entry_rd = ent[i];
  end

  irw_rdmux #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_rd (
    .off_sel_i(off_sel), .off_win_i(off_win), .len_ok_i(len_ok), .lane_i(lane),
    .kind_i(kind), .hi_i(hi), .sel_i(sel_q), .id_i(id_q), .entry_i(entry_rd),
    .rdata_o(bus_rdata_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_wr_o  <= 1'b0;
      entry_idx_o <= '0;
      mask_chg_o  <= 1'b0;
    end else begin
      entry_wr_o <= tbl_we;
      mask_chg_o <= |mask_flip;
      if (tbl_we) entry_idx_o <= tbl_idx;
    end
  end

  assert_sel_low_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we |=> (sel_q == $past(wdata_eff[7:0])));
  assert_single_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_lo | we_hi));
  assert_no_void_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_i && bus_write_i && off_win && kind == K_VOID |=> !entry_wr_o);
  assert_mask_with_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_chg_o |-> entry_wr_o);
  assert_strobe_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we |=> entry_wr_o && entry_idx_o == $past(tbl_idx));
endmodule

// File: tb/irq_regwin_test.sv
module irq_regwin_test;
  localparam int CLK_P = 10;
  localparam int NP    = 24;
  localparam int AW    = 12;
  localparam int IW    = $clog2(NP);

  logic clk = 0, rst_n = 0;
  logic valid = 0, write = 0;
  logic [AW-1:0] addr = '0;
  logic [3:0] len = 4'd4;
  logic [31:0] wdata = '0, rdata;
  logic [NP-1:0] rirr = '0;
  logic [NP*64-1:0] tbl, snap;
  logic ewr, mchg;
  logic [IW-1:0] eidx;
  logic s_ewr, s_mchg;
  logic [IW-1:0] s_idx;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  irq_regwin #(.NUM_PINS(NP), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(write),
    .bus_addr_i(addr), .bus_len_i(len), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rirr_set_i(rirr), .table_o(tbl), .entry_wr_o(ewr), .entry_idx_o(eidx),
    .mask_chg_o(mchg));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic [3:0] l = 4'd4);
    @(negedge clk);
    valid = 1; write = 1; addr = a; wdata = d; len = l;
    @(negedge clk);
    valid = 0; write = 0;
    #1;
    s_ewr = ewr; s_mchg = mchg; s_idx = eidx;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag, logic [3:0] l = 4'd4);
    exp_t e;
    @(negedge clk);
    valid = 1; write = 0; addr = a; len = l;
    e.exp = exp; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    valid = 0;
  endtask

  task automatic sel(logic [7:0] s);
    wr(12'h000, {24'b0, s});
  endtask

  // monitor: compares read data a quarter period after the driver
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (valid && !write) begin
        if (q.size() == 0) chk("unexpected read", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.tag, {32'b0, rdata}, {32'b0, e.exp});
        end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8 reset state
    rd(12'h000, 32'h0, "R8 select after reset");
    sel(8'h10);
    rd(12'h010, 32'h0001_0000, "R8 entry0 low after reset");
    chk("R8 table entry5 reset", tbl[5*64 +: 64], 64'h0000_0000_0001_0000);
    sel(8'h00);
    rd(12'h010, 32'h0, "R8 id after reset");

    // R4 identifier and arbitration
    wr(12'h010, 32'hFA12_3456);
    rd(12'h010, 32'h0A00_0000, "R4 id write");
    sel(8'h02);
    rd(12'h010, 32'h0A00_0000, "R4 arb read");
    wr(12'h010, 32'h0500_0000);
    chk("R4 arb write no strobe", s_ewr, 0);
    sel(8'h00);
    rd(12'h010, 32'h0A00_0000, "R4 arb write ignored");

    // R5 version
    sel(8'h01);
    rd(12'h010, 32'h0017_0011, "R5 version");
    wr(12'h010, 32'h1234_5678);
    rd(12'h010, 32'h0017_0011, "R5 version write ignored");

    // R3 lengths
    rd(12'h010, 32'h0000_0011, "R3 read len1", 4'd1);
    rd(12'h010, 32'h0000_0011, "R3 read len2", 4'd2);
    rd(12'h010, 32'h0017_0011, "R3 read len8", 4'd8);
    rd(12'h010, 32'h0, "R3 read len3", 4'd3);
    wr(12'h000, 32'h0000_ABCD, 4'd1);
    rd(12'h000, 32'h0000_00CD, "R3 write len1");
    wr(12'h000, 32'h0000_0020, 4'd3);
    rd(12'h000, 32'h0000_00CD, "R3 bad length write dropped");

    // R2 select low byte
    wr(12'h000, 32'h1234_5616);
    rd(12'h000, 32'h0000_0016, "R2 select keeps low byte");

    // R6 R9 R10 R11 entry 3 (select 0x16 low, 0x17 high)
    wr(12'h010, 32'h0000_C031);
    chk("R10 strobe low write", s_ewr, 1);
    chk("R10 index low write", s_idx, 3);
    chk("R10 mask change", s_mchg, 1);
    rd(12'h010, 32'h0000_8031, "R9 low write clears remote irr bit14");
    sel(8'h17);
    wr(12'h010, 32'hAB00_0000);
    chk("R10 strobe high write", s_ewr, 1);
    chk("R10 no mask change on high write", s_mchg, 0);
    rd(12'h010, 32'hAB00_0000, "R6 high half");
    chk("R11 table entry3", tbl[3*64 +: 64], 64'hAB00_0000_0000_8031);
    chk("R6 neighbour entry2 untouched", tbl[2*64 +: 64], 64'h0000_0000_0001_0000);

    @(negedge clk); rirr[3] = 1;
    @(negedge clk); rirr = '0;
    chk("R9 remote irr set", tbl[3*64 + 14], 1);
    wr(12'h010, 32'hCD00_0000);
    sel(8'h16);
    rd(12'h010, 32'h0000_C031, "R9 high write keeps remote irr");
    wr(12'h010, 32'h0000_8031);
    chk("R10 no mask change same mask", s_mchg, 0);
    rd(12'h010, 32'h0000_8031, "R9 low write clears remote irr");

    // R9 set wins over simultaneous low write
    @(negedge clk);
    valid = 1; write = 1; addr = 12'h010; wdata = 32'h0000_8031; len = 4'd4; rirr[3] = 1;
    @(negedge clk);
    valid = 0; write = 0; rirr = '0;
    chk("R9 set wins", tbl[3*64 + 14], 1);

    // R6 last entry 23: select 0x3E / 0x3F
    sel(8'h3F);
    wr(12'h010, 32'h5500_0000);
    chk("R10 index last entry", s_idx, 23);
    chk("R11 last entry high", tbl[23*64 +: 64], 64'h5500_0000_0001_0000);

    // R7 out of range
    snap = tbl;
    sel(8'h40);
    rd(12'h010, 32'hFFFF_FFFF, "R7 index beyond pins");
    wr(12'h010, 32'h0000_0000);
    chk("R7 no strobe out of range", s_ewr, 0);
    chk("R7 table unchanged", tbl, snap);
    sel(8'h05);
    rd(12'h010, 32'hFFFF_FFFF, "R7 select 0x05");
    wr(12'h010, 32'h0);
    chk("R7 table unchanged low select", tbl, snap);

    // R1 decode
    rd(12'h020, 32'h0, "R1 other offset reads zero");
    wr(12'h020, 32'h0000_0044);
    rd(12'h000, 32'h0000_0005, "R1 other offset write ignored");
    wr(12'h100, 32'h0000_0001);
    rd(12'h110, 32'h0017_0011, "R1 upper address bits ignored");

    repeat (2) @(negedge clk);
    chk("scoreboard drained", q.size(), 0);
    finish_run();
  end
endmodule